// File: doc/BRIEF.md
# UART Receive Error and Receiver-Enable State Register

This block holds the sticky receive-side error status of a UART (parity, framing and receive overrun) and the receiver-enable state. The receiver datapath feeds it per-character error indications and a separate overrun pulse. The block drives the receiver-enable line and a level error interrupt request. Detecting errors on the serial line and storing characters are handled elsewhere.

Software reaches the block through a small register port. A control register holds one detection enable per error type and an error interrupt enable. A read-only state register shows the flags and the receiver enable. A write-only command register is the only way to change the flags and the receiver enable. Each of its bits sets or clears exactly one item, so a driver never needs a read-modify-write to acknowledge an error. Writing 1 to a bit acts on its item. Writing 0 leaves the item as it is.

An overrun is reported as an event of its own. It never marks the character being received as bad. The per-character verdict comes out separately, one cycle after the character is presented.

Top module: `rxerr_state_regs`

## Requirements
- R1: After reset the control register, all three error flags, the receiver enable, the error interrupt and the character verdict are 0.
- R2: The control register is at address 0. Bit 4 enables parity checking, bit 17 enables framing detection, bit 19 enables receive overrun detection, bit 20 enables transmit overrun detection (stored only) and bit 24 enables the error interrupt. The register reads back these bits, and every other bit reads 0.
- R3: The state register is at address 1. It shows receiver enable at bit 15, the parity flag at bit 16, the framing flag at bit 17 and the overrun flag at bit 19, with all other bits 0. Writes to address 1 change nothing.
- R4: A flag sets on the clock edge that samples its event, and only when the matching control enable is 1. A parity event is chr_valid with chr_par_err. A framing event is chr_valid with chr_frm_err. An overrun event is ovr_pulse. Flags then hold until cleared.
- R5: The command register is at address 2 and always reads 0. When writing to it, bit 0 clears the receiver enable, bit 1 sets it (set wins if both are 1), bit 2 clears the parity flag, bit 3 clears the framing flag and bit 5 clears the overrun flag. All other bits have no effect.
- R6: A single command write of 0x2C clears all three error flags at once.
- R7: When a clear and a new accepted event of the same flag meet in one cycle, the flag ends up set.
- R8: err_irq is high exactly when the interrupt enable (control bit 24) is 1 and at least one error flag is set. It follows the flags with no added delay.
- R9: chr_flagged is registered. It is high in the cycle after an accepted parity or framing event and low otherwise. An overrun event never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 state, 2 command) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| chr_valid | input | 1 | A received character is presented this cycle |
| chr_par_err | input | 1 | Parity error on the presented character |
| chr_frm_err | input | 1 | Framing error on the presented character |
| ovr_pulse | input | 1 | Receive overrun event |
| rx_enable | output | 1 | Receiver enable |
| err_irq | output | 1 | Error interrupt request |
| chr_flagged | output | 1 | Presented character was accepted as bad (one cycle later) |

## Verification
Every state change (flags, receiver enable, control contents, chr_flagged) is due one clock edge after the write or event that causes it. bus_rdata and err_irq are combinational on that state and on bus_addr. The bench's reference model therefore updates on the same rising edge as the design and compares all outputs 1 ns after each rising edge, after the registers have settled and well before the inputs change at the falling edge. Directed reads drive the address at a falling edge and sample the read data 1 ns later, so that the same-cycle clear-versus-event case and the command register's zero readback are seen exactly when they are due.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

  localparam int NUM_ERR = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;

  localparam int REG_CTRL   = 0;
  localparam int REG_STATE  = 1;
  localparam int REG_SETCLR = 2;

  localparam int CT_PAR_EN   = 4;
  localparam int CT_FRM_EN   = 17;
  localparam int CT_OVR_EN   = 19;
  localparam int CT_TXOVR_EN = 20;
  localparam int CT_IRQ_EN   = 24;

  localparam int ST_RXEN     = 15;
  localparam int SC_RXEN_CLR = 0;
  localparam int SC_RXEN_SET = 1;

  typedef struct packed {
    logic irq_en;
    logic txovr_en;
    logic ovr_en;
    logic frm_en;
    logic par_en;
  } ctrl_t;

  // state register bit of error flag i
  function automatic int flag_pos(input int i);
    case (i)
      ERR_PAR: return 16;
      ERR_FRM: return 17;
      default: return 19;
    endcase
  endfunction

  // command register bit that clears error flag i
  function automatic int clr_pos(input int i);
    case (i)
      ERR_PAR: return 2;
      ERR_FRM: return 3;
      default: return 5;
    endcase
  endfunction

  // detection enable of error type i
  function automatic logic det_enable(input ctrl_t c, input int i);
    case (i)
      ERR_PAR: return c.par_en;
      ERR_FRM: return c.frm_en;
      default: return c.ovr_en;
    endcase
  endfunction

  // a new event outranks a clear
  function automatic logic flag_next(input logic cur, input logic hit, input logic clr);
    return hit | (cur & ~clr);
  endfunction

  // a set outranks a clear
  function automatic logic rxen_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/rxerr_ctrl_reg.sv
module rxerr_ctrl_reg
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl
);

  ctrl_t ctrl_q;
  logic  unused_wdata;

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.par_en   <= wdata[CT_PAR_EN];
      ctrl_q.frm_en   <= wdata[CT_FRM_EN];
      ctrl_q.ovr_en   <= wdata[CT_OVR_EN];
      ctrl_q.txovr_en <= wdata[CT_TXOVR_EN];
      ctrl_q.irq_en   <= wdata[CT_IRQ_EN];
    end
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/rxerr_state_bank.sv
module rxerr_state_bank
  import rxerr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] hit,
  input  logic [NUM_ERR-1:0] clr,
  input  logic               rxen_set,
  input  logic               rxen_clr,
  output logic [NUM_ERR-1:0] flags,
  output logic               rxen,
  output logic               chr_bad
);

  logic [NUM_ERR-1:0] flag_q;
  logic               rxen_q;
  logic               chr_bad_q;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_next(flag_q[i], hit[i], clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen_q    <= 1'b0;
      chr_bad_q <= 1'b0;
    end else begin
      rxen_q    <= rxen_next(rxen_q, rxen_set, rxen_clr);
      // overrun is reported separately and never marks the character
      chr_bad_q <= hit[ERR_PAR] | hit[ERR_FRM];
    end
  end

  assign flags   = flag_q;
  assign rxen    = rxen_q;
  assign chr_bad = chr_bad_q;

endmodule

// File: rtl/rxerr_readback.sv
module rxerr_readback
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  ctrl_t              ctrl,
  input  logic [NUM_ERR-1:0] flags,
  input  logic               rxen,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] state_word;

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CT_PAR_EN]   = ctrl.par_en;
    ctrl_word[CT_FRM_EN]   = ctrl.frm_en;
    ctrl_word[CT_OVR_EN]   = ctrl.ovr_en;
    ctrl_word[CT_TXOVR_EN] = ctrl.txovr_en;
    ctrl_word[CT_IRQ_EN]   = ctrl.irq_en;
  end

  always_comb begin
    state_word           = '0;
    state_word[ST_RXEN]  = rxen;
    for (int i = 0; i < NUM_ERR; i++) begin
      state_word[flag_pos(i)] = flags[i];
    end
  end

  always_comb begin
    if (addr == ADDR_W'(REG_CTRL))       rdata = ctrl_word;
    else if (addr == ADDR_W'(REG_STATE)) rdata = state_word;
    else                                 rdata = '0;  // command register reads zero
  end

endmodule

// File: rtl/rxerr_state_regs.sv
module rxerr_state_regs
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              chr_valid,
  input  logic              chr_par_err,
  input  logic              chr_frm_err,
  input  logic              ovr_pulse,
  output logic              rx_enable,
  output logic              err_irq,
  output logic              chr_flagged
);

  ctrl_t              ctrl;
  logic               wr_ctrl;
  logic               wr_cmd;
  logic [NUM_ERR-1:0] evt;
  logic [NUM_ERR-1:0] hit;
  logic [NUM_ERR-1:0] clr;
  logic               rxen_set;
  logic               rxen_clr;
  logic [NUM_ERR-1:0] flags;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(REG_SETCLR));

  assign evt[ERR_PAR] = chr_valid & chr_par_err;
  assign evt[ERR_FRM] = chr_valid & chr_frm_err;
  assign evt[ERR_OVR] = ovr_pulse;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_evt
    assign hit[i] = evt[i] & det_enable(ctrl, i);
    assign clr[i] = wr_cmd & bus_wdata[clr_pos(i)];
  end

  assign rxen_set = wr_cmd & bus_wdata[SC_RXEN_SET];
  assign rxen_clr = wr_cmd & bus_wdata[SC_RXEN_CLR];

  rxerr_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ctrl),
    .wdata (bus_wdata),
    .ctrl  (ctrl)
  );

  rxerr_state_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr      (clr),
    .rxen_set (rxen_set),
    .rxen_clr (rxen_clr),
    .flags    (flags),
    .rxen     (rx_enable),
    .chr_bad  (chr_flagged)
  );

  rxerr_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rb (
    .addr  (bus_addr),
    .ctrl  (ctrl),
    .flags (flags),
    .rxen  (rx_enable),
    .rdata (bus_rdata)
  );

  assign err_irq = ctrl.irq_en & (|flags);

endmodule

// File: rtl/rxerr_state_regs_chk.sv
module rxerr_state_regs_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int NUM_ERR = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ERR-1:0] hit,
  input logic [NUM_ERR-1:0] clr,
  input logic [NUM_ERR-1:0] flags,
  input logic               rxen_set,
  input logic               rxen_clr,
  input logic               rx_enable,
  input logic               irq_en,
  input logic               err_irq,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               chr_valid,
  input logic               ovr_pulse,
  input logic               chr_flagged
);

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag_chk
    p_rise_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(hit[i]));
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[i] && !clr[i]) |=> $stable(flags[i]));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !hit[i]) |=> !flags[i]);
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i]);
  end

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> irq_en);
  p_irq_raised_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (|flags)) |-> err_irq);
  p_rxen_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rxen_set |=> rx_enable);
  p_rxen_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxen_clr && !rxen_set) |=> !rx_enable);
  p_cmd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(2)) |-> (bus_rdata == '0));
  p_overrun_not_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pulse && !chr_valid) |=> !chr_flagged);

endmodule

bind rxerr_state_regs rxerr_state_regs_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .NUM_ERR(rxerr_pkg::NUM_ERR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit         (hit),
  .clr         (clr),
  .flags       (flags),
  .rxen_set    (rxen_set),
  .rxen_clr    (rxen_clr),
  .rx_enable   (rx_enable),
  .irq_en      (ctrl.irq_en),
  .err_irq     (err_irq),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .chr_valid   (chr_valid),
  .ovr_pulse   (ovr_pulse),
  .chr_flagged (chr_flagged)
);

// File: tb/tb_rxerr_state_regs.sv
`timescale 1ns/1ps
module tb_rxerr_state_regs;

  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          chr_valid = 1'b0;
  logic          chr_par_err = 1'b0;
  logic          chr_frm_err = 1'b0;
  logic          ovr_pulse = 1'b0;
  logic          rx_enable;
  logic          err_irq;
  logic          chr_flagged;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rxerr_state_regs #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chr_valid(chr_valid),
    .chr_par_err(chr_par_err), .chr_frm_err(chr_frm_err), .ovr_pulse(ovr_pulse),
    .rx_enable(rx_enable), .err_irq(err_irq), .chr_flagged(chr_flagged)
  );

  // ---------------- reference model ----------------
  int unsigned m_ctrl = 0;
  bit m_par = 0, m_frm = 0, m_ovr = 0, m_rxen = 0, m_bad = 0;
  bit m_live = 0;

  always @(posedge clk) begin
    bit hp, hf, ho;
    if (!rst_n) begin
      m_ctrl = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_rxen = 0; m_bad = 0;
    end else begin
      hp = chr_valid && chr_par_err && m_ctrl[4];
      hf = chr_valid && chr_frm_err && m_ctrl[17];
      ho = ovr_pulse && m_ctrl[19];
      m_bad = hp || hf;
      if (bus_wr && bus_addr == 2) begin
        if (bus_wdata[2]) m_par = 0;
        if (bus_wdata[3]) m_frm = 0;
        if (bus_wdata[5]) m_ovr = 0;
        if (bus_wdata[0]) m_rxen = 0;
        if (bus_wdata[1]) m_rxen = 1;
      end
      if (hp) m_par = 1;
      if (hf) m_frm = 1;
      if (ho) m_ovr = 1;
      if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata & 32'h011A_0010;
    end
    m_live = 1;
  end

  function automatic int unsigned model_state();
    return (int'(m_rxen) << 15) | (int'(m_par) << 16) | (int'(m_frm) << 17) | (int'(m_ovr) << 19);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (m_live && !finished) begin
      int unsigned exp_rd;
      string tag;
      case (bus_addr)
        2'd0: begin exp_rd = m_ctrl; tag = "R2 ctrl readback"; end
        2'd1: begin exp_rd = model_state(); tag = "R3 state readback"; end
        default: begin exp_rd = 0; tag = "R5 command reads zero"; end
      endcase
      check(tag, bus_rdata, exp_rd);
      check("R5 rx_enable", {31'd0, rx_enable}, {31'd0, m_rxen});
      check("R8 err_irq", {31'd0, err_irq},
            {31'd0, m_ctrl[24] && (m_par || m_frm || m_ovr)});
      check("R9 chr_flagged", {31'd0, chr_flagged}, {31'd0, m_bad});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    @(negedge clk);
    bus_wr = 0; chr_valid = 0; chr_par_err = 0; chr_frm_err = 0; ovr_pulse = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    idle();
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic events(input bit v, input bit pe, input bit fe, input bit ov);
    @(negedge clk);
    chr_valid = v; chr_par_err = pe; chr_frm_err = fe; ovr_pulse = ov;
    idle();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  logic [31:0] rnd = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R1 reset state
    rd_chk(0, 32'h0, "R1 ctrl after reset");
    rd_chk(1, 32'h0, "R1 state after reset");
    check("R1 irq after reset", {31'd0, err_irq}, 32'd0);
    check("R1 verdict after reset", {31'd0, chr_flagged}, 32'd0);
    // R4 events with every enable off latch nothing
    events(1, 1, 1, 1);
    rd_chk(1, 32'h0, "R4 disabled events ignored");
    check("R9 no verdict while disabled", {31'd0, chr_flagged}, 32'd0);
    // R2 masking of control bits
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h011A_0010, "R2 ctrl mask");
    wr(0, 32'h010A_0010);
    rd_chk(0, 32'h010A_0010, "R2 ctrl value");
    // R5 receiver enable
    wr(2, 32'h2);
    check("R5 rx enable set", {31'd0, rx_enable}, 32'd1);
    rd_chk(1, 32'h0000_8000, "R3 rx enable bit");
    // R4 / R9 / R8 parity
    @(negedge clk); chr_valid = 1; chr_par_err = 1;
    idle();
    check("R9 parity verdict", {31'd0, chr_flagged}, 32'd1);
    check("R8 irq on parity", {31'd0, err_irq}, 32'd1);
    rd_chk(1, 32'h0001_8000, "R4 parity flag");
    // R9 overrun alone
    events(0, 0, 0, 1);
    check("R9 overrun no verdict", {31'd0, chr_flagged}, 32'd0);
    rd_chk(1, 32'h0009_8000, "R4 overrun flag");
    events(1, 0, 1, 0);
    rd_chk(1, 32'h000B_8000, "R4 framing flag");
    // R6 one write clears all
    wr(2, 32'h2C);
    rd_chk(1, 32'h0000_8000, "R6 clear all");
    check("R8 irq after clear", {31'd0, err_irq}, 32'd0);
    // R7 clear and event together
    @(negedge clk);
    bus_wr = 1; bus_addr = 2; bus_wdata = 32'h4; chr_valid = 1; chr_par_err = 1;
    idle();
    rd_chk(1, 32'h0001_8000, "R7 event beats clear");
    // R5 set wins, then clear
    wr(2, 32'h3);
    check("R5 set wins", {31'd0, rx_enable}, 32'd1);
    wr(2, 32'h1);
    check("R5 rx enable clear", {31'd0, rx_enable}, 32'd0);
    // R8 interrupt enable off
    wr(0, 32'h000A_0010);
    check("R8 irq masked", {31'd0, err_irq}, 32'd0);
    // R3 state writes ignored, R5 unused command bits ignored
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h0001_0000, "R3 state write ignored");
    wr(2, 32'hFFFF_FFD0);
    rd_chk(1, 32'h0001_0000, "R5 unused command bits");
    rd_chk(2, 32'h0, "R5 command readback");
    // mixed traffic, checked by the model every cycle
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      bus_wr      = rnd[0] & rnd[1];
      bus_addr    = rnd[3:2];
      bus_wdata   = (rnd[4] ? rnd : {rnd[7:0], 24'h0}) | {rnd[9:8], 30'h0};
      if (bus_addr == 0 && rnd[10]) bus_wdata = rnd[11] ? 32'h011A_0010 : 32'h010A_0010;
      chr_valid   = rnd[12];
      chr_par_err = rnd[13];
      chr_frm_err = rnd[14];
      ovr_pulse   = rnd[15] & rnd[16];
    end
    idle();
    idle();
    finish_run();
  end

endmodule